// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a small direct-mapped data cache that sits after address translation, so it is indexed and tagged with physical addresses. Every line holds exactly one data word, a tag and a valid flag. A read looks up the line chosen by the index field. If that line is valid and its stored tag matches, the word is returned in the same cycle. Otherwise the block raises a stall and asks memory for the word. The requester holds its request steady while the stall is high. Memory answers through a refill port, and on the cycle after the refill the held read completes.

Writes follow a write-through policy and never test for a hit. An accepted write overwrites the indexed line's tag and data and sets it valid. It also queues the address and word into a small first-in first-out write buffer, which drains toward memory through a valid/ready port. Because a line is one word wide, no read-before-write or allocate step is needed. A write stalls only while the write buffer is full.

Top module: `wt_dcache`

## Requirements
- R1: The address splits into a byte offset in bits [OFF_W-1:0], which is ignored by lookups, an index in the next IDX_W bits, and a tag in the remaining upper bits. A hit needs the stored tag to equal the request tag.
- R2: After synchronous active-low reset every line is invalid, so every read misses.
- R3: A read to a valid line with a matching tag raises `rsp_hit`, returns the stored word on `rsp_rdata` in the same cycle, and keeps `stall` low.
- R4: A read miss raises `stall` and `fill_req` in the same cycle and presents the word-aligned request address (offset bits zero) on `fill_addr`.
- R5: A refill writes the word and tag into the line selected by `refill_addr` and marks it valid. A read held on that address hits with the refilled word on the cycle after the refill.
- R6: An accepted write replaces the indexed line's tag and data and makes it valid, whatever the line held before. A later read of the old tag at that index misses.
- R7: Each accepted write enqueues its full address and data. Entries leave on `wb_addr`/`wb_data` in acceptance order, one per cycle in which `wb_valid` and `wb_ready` are both high, and the head stays stable while it waits.
- R8: The write buffer holds WB_DEPTH entries (default 4). A write that arrives while it is full raises `stall`, and leaves both the cache line and the buffer unchanged until a later cycle in which it is accepted.
- R9: When a processor write and a refill land in the same cycle, the write wins on a shared index. On different indices both updates take effect.
- R10: `wb_valid` is low whenever the write buffer is empty, including right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_hit | output | 1 | Read hit, read data valid this cycle |
| rsp_rdata | output | DATA_W | Read data |
| stall | output | 1 | Request not completed this cycle; hold it |
| fill_req | output | 1 | Read miss, word wanted from memory |
| fill_addr | output | ADDR_W | Word-aligned address of the missing word |
| refill_valid | input | 1 | Refill word present |
| refill_addr | input | ADDR_W | Address of the refill word |
| refill_data | input | DATA_W | Refill word |
| wb_valid | output | 1 | Write buffer head present |
| wb_addr | output | ADDR_W | Head entry address |
| wb_data | output | DATA_W | Head entry data |
| wb_ready | input | 1 | Memory takes the head entry this cycle |

## Verification
Lookup results (`rsp_hit`, `rsp_rdata`, `stall`, `fill_req`, `fill_addr`) are combinational, so they are due in the same cycle as the request. The bench drives inputs two time units after a rising edge and samples at the following falling edge. A write or refill changes the line on the next rising edge, so the read that observes it is placed in the cycle after. The write buffer's head becomes visible one edge after acceptance. A monitor therefore compares each drained entry at the falling edge before the edge that pops it, against a queue filled at acceptance time.

// File: rtl/wtc_pkg.sv
// Package wtc_pkg
// Shared types for the write-through cache. Assumes nothing beyond
// a standard 2-state/4-state SystemVerilog flow.
package wtc_pkg;

    // Kind of processor request seen in the current cycle.
    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_READ  = 2'd1,
        RQ_WRITE = 2'd2
    } req_kind_e;

    // Decision taken on the current request.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_RD_HIT  = 2'd1,
        ACT_RD_MISS = 2'd2,
        ACT_WR_ACC  = 2'd3
    } req_act_e;

endpackage

// File: rtl/wtc_line_store.sv
// Module wtc_line_store
// One-word-per-line storage: valid flags (reset), tags and data
// (no reset). Asynchronous lookup port, two synchronous write ports.
// Port A (processor) overrides port B (refill) on the same index.
// Assumes IDX_W is small enough for a flop array in the target use.
module wtc_line_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              a_en,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_en,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [TAG_W-1:0]  b_tag,
    input  logic [DATA_W-1:0] b_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid flags: cleared by reset, set by either write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (b_en) vld_q[b_idx] <= 1'b1;
            if (a_en) vld_q[a_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: refill first, processor write last so it wins.
    always_ff @(posedge clk) begin
        if (b_en) begin
            tag_q[b_idx]  <= b_tag;
            data_q[b_idx] <= b_data;
        end
        if (a_en) begin
            tag_q[a_idx]  <= a_tag;
            data_q[a_idx] <= a_data;
        end
    end

    // Lookup: hit needs a valid line and an equal tag.
    always_comb begin
        lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_data = data_q[lk_idx];
    end

    // R6: a processor write leaves its line valid.
    p_wr_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_en |=> vld_q[$past(a_idx)]);

    // R9: on a shared index the processor write's tag and data survive.
    p_cpu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && (a_idx == b_idx)) |=>
            (tag_q[$past(a_idx)] == $past(a_tag)) &&
            (data_q[$past(a_idx)] == $past(a_data)));

endmodule

// File: rtl/wtc_wbuf.sv
// Module wtc_wbuf
// Write buffer: DEPTH-entry FIFO of W-bit entries with a valid/ready
// drain side. Assumes the producer never pushes while full (the
// controller stalls instead). DEPTH must be at least 2.
module wtc_wbuf #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    // Status and head view.
    always_comb begin
        full      = (cnt_q == FULL_CNT);
        out_valid = (cnt_q != '0);
        out_data  = mem_q[rd_ptr_q];
        pop       = out_valid && out_ready;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= push_data;
    end

    // R8: nothing is pushed into a full buffer.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: a waiting head stays presented and unchanged.
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/wtc_ctrl.sv
// Module wtc_ctrl
// Request decision logic: classifies the request, decides hit, miss
// or accepted write, and drives stall, fill request and write enables.
// Assumes the requester holds its request while stall is high.
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic     req_valid,
    input  logic     req_write,
    input  logic     lk_hit,
    input  logic     wb_full,
    output req_act_e act,
    output logic     stall,
    output logic     fill_req,
    output logic     rd_hit,
    output logic     wr_accept
);
    req_kind_e kind;

    // Classify the incoming request.
    always_comb begin
        if (!req_valid)     kind = RQ_IDLE;
        else if (req_write) kind = RQ_WRITE;
        else                kind = RQ_READ;
    end

    // Decide the action for this cycle.
    always_comb begin
        unique case (kind)
            RQ_READ:  act = lk_hit ? ACT_RD_HIT : ACT_RD_MISS;
            RQ_WRITE: act = wb_full ? ACT_NONE : ACT_WR_ACC;
            default:  act = ACT_NONE;
        endcase
    end

    // Drive the outputs from the action.
    always_comb begin
        rd_hit    = (act == ACT_RD_HIT);
        fill_req  = (act == ACT_RD_MISS);
        wr_accept = (act == ACT_WR_ACC);
        stall     = (act == ACT_RD_MISS) || ((kind == RQ_WRITE) && (act == ACT_NONE));
    end

endmodule

// File: rtl/wt_dcache.sv
// Module wt_dcache
// Physically addressed, direct-mapped, write-through data cache with
// one word per line and a FIFO write buffer toward memory.
// Assumes: requester holds a stalled request; refills arrive only for
// words the cache asked for; IDX_W + OFF_W < ADDR_W.
module wt_dcache
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 2,
    parameter int IDX_W    = 10,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stall,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_addr,
    input  logic [DATA_W-1:0] refill_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ready
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int ENT_W = ADDR_W + DATA_W;

    logic [IDX_W-1:0]  rq_idx, rf_idx;
    logic [TAG_W-1:0]  rq_tag, rf_tag;
    logic              lk_hit;
    logic              wb_full;
    logic              wr_accept;
    logic              rd_hit;
    req_act_e          act;
    logic [ENT_W-1:0]  wb_head;
    logic              unused_refill_off;

    // Address field split for the request and the refill.
    always_comb begin
        rq_idx = req_addr[OFF_W +: IDX_W];
        rq_tag = req_addr[ADDR_W-1 -: TAG_W];
        rf_idx = refill_addr[OFF_W +: IDX_W];
        rf_tag = refill_addr[ADDR_W-1 -: TAG_W];
        unused_refill_off = ^refill_addr[OFF_W-1:0];
    end

    wtc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (rq_idx),
        .lk_tag (rq_tag),
        .lk_hit (lk_hit),
        .lk_data(rsp_rdata),
        .a_en   (wr_accept),
        .a_idx  (rq_idx),
        .a_tag  (rq_tag),
        .a_data (req_wdata),
        .b_en   (refill_valid),
        .b_idx  (rf_idx),
        .b_tag  (rf_tag),
        .b_data (refill_data)
    );

    wtc_ctrl u_ctrl (
        .req_valid(req_valid),
        .req_write(req_write),
        .lk_hit   (lk_hit),
        .wb_full  (wb_full),
        .act      (act),
        .stall    (stall),
        .fill_req (fill_req),
        .rd_hit   (rd_hit),
        .wr_accept(wr_accept)
    );

    wtc_wbuf #(
        .W    (ENT_W),
        .DEPTH(WB_DEPTH)
    ) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_accept),
        .push_data({req_addr, req_wdata}),
        .full     (wb_full),
        .out_valid(wb_valid),
        .out_data (wb_head),
        .out_ready(wb_ready)
    );

    // Response and memory-side outputs.
    always_comb begin
        rsp_hit   = rd_hit;
        fill_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        wb_addr   = wb_head[ENT_W-1 -: ADDR_W];
        wb_data   = wb_head[DATA_W-1:0];
    end

    // R3: a read hit never stalls.
    p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !stall);

    // R4: a fill request always comes with a stall.
    p_fill_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> stall);

    // R8: a write held off by a full buffer does not reach the line store.
    p_full_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && wb_full) |-> !wr_accept);

    // R10: after reset the write buffer presents nothing.
    p_empty_after_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !wb_valid);

endmodule

// File: tb/wt_dcache_test.sv
module wt_dcache_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_hit, stall, fill_req;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] fill_addr;
    logic          refill_valid = 1'b0;
    logic [AW-1:0] refill_addr = '0;
    logic [DW-1:0] refill_data = '0;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic          wb_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Expected write-buffer traffic.
    logic [AW-1:0] sb_addr [64];
    logic [DW-1:0] sb_data [64];
    int sb_wr = 0;
    int sb_rd = 0;

    always #5 clk = ~clk;

    // Index width 4: index = addr[5:2], tag = addr[31:6].
    wt_dcache #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(2), .IDX_W(4), .WB_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .stall(stall),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_data(refill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // R7: compare each drained entry at the falling edge before its pop edge.
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_ready) begin
            if (sb_rd < sb_wr) begin
                chk(wb_addr == sb_addr[sb_rd], "R7 addr", wb_addr, sb_addr[sb_rd]);
                chk(wb_data == sb_data[sb_rd], "R7 data", wb_data, sb_data[sb_rd]);
            end else begin
                chk(1'b0, "R7 unexpected drain", wb_addr, 32'h0);
            end
            sb_rd++;
        end
    end

    // Read: results are due in the request cycle.
    task automatic rd(input logic [31:0] a, input bit ehit, input logic [31:0] ed, input string rq);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        chk(rsp_hit == ehit, rq, {31'b0, rsp_hit}, {31'b0, ehit});
        chk(stall == !ehit, rq, {31'b0, stall}, {31'b0, !ehit});
        if (ehit) chk(rsp_rdata == ed, rq, rsp_rdata, ed);
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    // Write, retried until accepted.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bit acc = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!acc) begin
            @(negedge clk);
            if (!stall) begin
                acc = 1;
                sb_addr[sb_wr] = a; sb_data[sb_wr] = d; sb_wr++;
            end
            @(posedge clk); #2;
        end
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    typedef struct packed {
        logic        is_wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic        hit;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0040, 32'h0,         1'b0}, // R2 fresh line misses
        '{1'b1, 32'h0000_0040, 32'h1111_1111, 1'b0}, // R6 write idx0 tag1
        '{1'b0, 32'h0000_0040, 32'h1111_1111, 1'b1}, // R3 hit
        '{1'b0, 32'h0000_0043, 32'h1111_1111, 1'b1}, // R1 offset ignored
        '{1'b0, 32'h0000_0080, 32'h0,         1'b0}, // R1 tag differs
        '{1'b1, 32'h0000_0080, 32'h2222_2222, 1'b0}, // R6 overwrite other tag
        '{1'b0, 32'h0000_0080, 32'h2222_2222, 1'b1}, // R6 new tag hits
        '{1'b0, 32'h0000_0040, 32'h0,         1'b0}, // R6 old tag gone
        '{1'b1, 32'h0000_0104, 32'h3333_3333, 1'b0}, // R6 idx1
        '{1'b0, 32'h0000_0104, 32'h3333_3333, 1'b1}, // R3 hit idx1
        '{1'b0, 32'h0000_0144, 32'h0,         1'b0}  // R1 idx1 other tag
    };

    initial begin
        // Reset state.
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(wb_valid == 1'b0, "R10 empty after reset", {31'b0, wb_valid}, 32'h0);
        @(posedge clk); #2;
        rd(32'h0000_0000, 1'b0, 32'h0, "R2 reset idx0");
        rd(32'h0000_003C, 1'b0, 32'h0, "R2 reset idx15");

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) wr(VEC[i].addr, VEC[i].data);
            else rd(VEC[i].addr, VEC[i].hit, VEC[i].data, $sformatf("R3/R6 vec %0d", i));
        end

        // R4/R5: miss, fill request, refill, then hit.
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_018B;
        @(negedge clk);
        chk(stall && fill_req, "R4 miss stalls", {30'b0, stall, fill_req}, 32'h3);
        chk(fill_addr == 32'h0000_0188, "R4 fill_addr aligned", fill_addr, 32'h0000_0188);
        @(posedge clk); #2;
        refill_valid = 1'b1; refill_addr = 32'h0000_0188; refill_data = 32'h5555_AAAA;
        @(negedge clk);
        chk(stall == 1'b1, "R5 still stalled in refill cycle", {31'b0, stall}, 32'h1);
        @(posedge clk); #2;
        refill_valid = 1'b0;
        @(negedge clk);
        chk(!stall && rsp_hit, "R5 hit after refill", {30'b0, stall, rsp_hit}, 32'h1);
        chk(rsp_rdata == 32'h5555_AAAA, "R5 refilled data", rsp_rdata, 32'h5555_AAAA);
        @(posedge clk); #2;
        req_valid = 1'b0;

        // R8: full buffer stalls a write and leaves the line untouched.
        wait (!wb_valid);
        @(posedge clk); #2;
        wb_ready = 1'b0;
        wr(32'h0000_020C, 32'hA0);
        wr(32'h0000_0210, 32'hA1);
        wr(32'h0000_0214, 32'hA2);
        wr(32'h0000_0218, 32'hA3);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_021C; req_wdata = 32'hA4;
        @(negedge clk);
        chk(stall == 1'b1, "R8 write stalls when full", {31'b0, stall}, 32'h1);
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0;
        rd(32'h0000_021C, 1'b0, 32'h0, "R8 stalled write left line alone");
        @(negedge clk);
        chk(wb_addr == 32'h0000_020C, "R8 buffer head unchanged", wb_addr, 32'h0000_020C);
        @(posedge clk); #2;
        wb_ready = 1'b1;
        wr(32'h0000_021C, 32'hA4);
        rd(32'h0000_021C, 1'b1, 32'hA4, "R8 write taken after drain");

        // R9: write and refill in one cycle.
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0240; req_wdata = 32'h77;
        refill_valid = 1'b1; refill_addr = 32'h0000_0280; refill_data = 32'h88;
        @(negedge clk);
        if (!stall) begin sb_addr[sb_wr] = 32'h0000_0240; sb_data[sb_wr] = 32'h77; sb_wr++; end
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0244; req_wdata = 32'h99;
        refill_valid = 1'b1; refill_addr = 32'h0000_02C8; refill_data = 32'hBB;
        @(negedge clk);
        if (!stall) begin sb_addr[sb_wr] = 32'h0000_0244; sb_data[sb_wr] = 32'h99; sb_wr++; end
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0; refill_valid = 1'b0;
        rd(32'h0000_0240, 1'b1, 32'h77, "R9 write wins same index");
        rd(32'h0000_0280, 1'b0, 32'h0,  "R9 refill dropped same index");
        rd(32'h0000_0244, 1'b1, 32'h99, "R9 write other index");
        rd(32'h0000_02C8, 1'b1, 32'hBB, "R9 refill other index");

        // R7/R10: everything drains in order, then the buffer is empty.
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(wb_valid == 1'b0, "R10 empty after drain", {31'b0, wb_valid}, 32'h0);
        chk(sb_rd == sb_wr, "R7 all entries drained", sb_rd, sb_wr);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule